// File: doc/BRIEF.md
# Accumulator Multiply-Divide Unit

This block is a multicycle arithmetic engine for integer multiply and divide built around a fixed register pair: an accumulator (the low half) and a data register (the high half). A one-operand multiply, unsigned or signed, takes the accumulator and a source operand. It returns a double-width product, with the high half headed for the data register and the low half for the accumulator. The two-operand and three-operand signed multiplies keep only the low half. The three-operand form takes an immediate as one factor. A divide takes a double-width dividend from the data:accumulator pair and a single-width divisor. It returns the quotient for the accumulator and the remainder for the data register.

A request is issued by pulsing `start` with the operation code and operands while the unit is idle. The unit runs a radix-2 shift-and-add or restoring-subtract loop of one iteration per operand bit. It then pulses `done` for one cycle with the results, the carry and overflow flags, and a `fault` indication. A fault means the divisor was zero or the quotient does not fit in the destination width. On a fault the result outputs keep their previous values, so nothing is written back.

Top module: `mdu_unit`

## Requirements
- R1: After reset `resHi`, `resLo`, `carryFlag`, `ovfFlag`, `busy`, `done` and `fault` are all 0.
- R2: Operation code 0 (unsigned one-operand multiply) places the unsigned product `accIn*srcIn` on {`resHi`,`resLo`}, with the high half on `resHi`.
- R3: Operation code 1 (signed one-operand multiply) places the two's-complement product of `accIn` and `srcIn` on {`resHi`,`resLo`}.
- R4: After any multiply, `carryFlag` and `ovfFlag` are equal. For code 0 they are 1 exactly when the high half of the product is nonzero. For the signed codes they are 1 exactly when the high half is not the sign extension of the low half.
- R5: Code 2 multiplies `accIn` by `srcIn` as signed values, and code 3 multiplies `immIn` by `srcIn` as signed values. Both place only the low half on `resLo` and leave `resHi` at its previous value.
- R6: Code 4 (unsigned divide; code 6 acts the same) divides {`dataIn`,`accIn`} by `srcIn`. It puts the quotient on `resLo` and the remainder on `resHi`.
- R7: Code 5 (signed divide; code 7 acts the same) truncates the quotient toward zero. The remainder carries the sign of the dividend.
- R8: A divide with `srcIn` zero, or with a quotient outside the destination range (unsigned, or signed), raises `fault` together with `done` and leaves `resHi` and `resLo` unchanged. `fault` is never high without `done`.
- R9: A `start` accepted while idle raises `busy` on the next cycle. `done` is a one-cycle pulse that appears W+1 clock edges after the accepting edge, in the same cycle `busy` falls.
- R10: `start` while `busy` is high is ignored: the running operation's results are unaffected and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| op | input | 3 | Operation code (see R2 to R7) |
| accIn | input | W | Accumulator value (low dividend half, multiply factor) |
| dataIn | input | W | Data register value (high dividend half) |
| srcIn | input | W | Source operand: multiplier or divisor |
| immIn | input | W | Immediate factor for the three-operand multiply |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide fault, valid with done |
| resHi | output | W | High half / remainder (data register image) |
| resLo | output | W | Low half / quotient (accumulator image) |
| carryFlag | output | 1 | Carry flag after multiply |
| ovfFlag | output | 1 | Overflow flag after multiply |

## Verification
The hardest situations to reach are the signed quotient boundaries. A quotient magnitude of exactly 2^(W-1) must pass when the result is negative and fault when it is positive. That corner is invisible to the unsigned pre-check on the high dividend half. The stimulus reaches it with dividends chosen as the most negative single-width value divided by plus and minus one, and as (2^(W-1))*(2^(W-1)-1) divided by 2^(W-1)-1. A second corner is a `start` arriving mid-run. It is driven several cycles into an operation with a different operation code and all-ones operands, and the bench then watches for an absent second completion.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  // Operation codes; bit 2 selects divide, bit 0 selects signed divide.
  typedef enum logic [2:0] {
    OP_MULU   = 3'd0,
    OP_IMUL1  = 3'd1,
    OP_IMUL2  = 3'd2,
    OP_IMUL3  = 3'd3,
    OP_DIVU   = 3'd4,
    OP_IDIV   = 3'd5,
    OP_DIVU_B = 3'd6,
    OP_IDIV_B = 3'd7
  } mduOpE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;    // capture operands and prepare magnitudes
    logic step;    // one radix-2 iteration
    logic finish;  // sign fix-up, fault decision, writeback
  } mduCtrlS;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mduCtrlS ctrl,
  output logic    busy
);

  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} stateE;

  stateE            state;
  logic [CNT_W-1:0] iterCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_ITER) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.step   = (state == ST_RUN);
    ctrl.finish = (state == ST_FIN);
    busy        = (state != ST_IDLE);
  end

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  mduCtrlS      ctrl,
  input  logic [2:0]   op,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] dataIn,
  input  logic [W-1:0] srcIn,
  input  logic [W-1:0] immIn,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         carryFlag,
  output logic         ovfFlag,
  output logic         done,
  output logic         fault
);

  localparam int DW = 2 * W;
  localparam logic [W-1:0] HALF_MAG = {1'b1, {(W-1){1'b0}}};

  // ---------------- operand preparation ----------------
  mduOpE         opIn;
  logic          inDiv, inSigned;
  logic [W-1:0]  factA;
  logic          aNeg, bNeg, dNeg;
  logic [W-1:0]  aMag, bMag;
  logic [DW-1:0] dividend, dMag;

  always_comb begin
    opIn     = mduOpE'(op);
    inDiv    = op[2];
    inSigned = op[2] ? op[0] : (op[1:0] != 2'b00);
    factA    = (opIn == OP_IMUL3) ? immIn : accIn;
    aNeg     = inSigned & factA[W-1];
    bNeg     = inSigned & srcIn[W-1];
    aMag     = aNeg ? (~factA + 1'b1) : factA;
    bMag     = bNeg ? (~srcIn + 1'b1) : srcIn;
    dividend = {dataIn, accIn};
    dNeg     = inSigned & dataIn[W-1];
    dMag     = dNeg ? (~dividend + 1'b1) : dividend;
  end

  // ---------------- iteration state ----------------
  mduOpE         opR;
  logic [DW-1:0] shreg;     // multiply: {partial, multiplier}; divide: {rem, quot}
  logic [W-1:0]  opndMag;   // multiplicand or divisor magnitude
  logic          negRes;
  logic          negRem;
  logic          preFault;

  logic [W:0]    mulSum;
  logic [W:0]    divShift, divDiff;
  logic          divGe;
  logic [DW-1:0] mulNext, divNext;

  always_comb begin
    mulSum   = {1'b0, shreg[DW-1:W]} + {1'b0, (shreg[0] ? opndMag : {W{1'b0}})};
    mulNext  = {mulSum, shreg[W-1:1]};
    divShift = shreg[DW-1:W-1];
    divDiff  = divShift - {1'b0, opndMag};
    divGe    = (divShift >= {1'b0, opndMag});
    divNext  = divGe ? {divDiff[W-1:0], shreg[W-2:0], 1'b1}
                     : {divShift[W-1:0], shreg[W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR      <= OP_MULU;
      shreg    <= '0;
      opndMag  <= '0;
      negRes   <= 1'b0;
      negRem   <= 1'b0;
      preFault <= 1'b0;
    end else if (ctrl.load) begin
      opR <= opIn;
      if (inDiv) begin
        shreg    <= dMag;
        opndMag  <= bMag;
        negRes   <= dNeg ^ bNeg;
        negRem   <= dNeg;
        preFault <= (bMag == '0) || (dMag[DW-1:W] >= bMag);
      end else begin
        shreg    <= {{W{1'b0}}, bMag};
        opndMag  <= aMag;
        negRes   <= aNeg ^ bNeg;
        negRem   <= 1'b0;
        preFault <= 1'b0;
      end
    end else if (ctrl.step) begin
      shreg <= opR[2] ? divNext : mulNext;
    end
  end

  // ---------------- final fix-up ----------------
  logic          isDivR, sgnDivR, sgnMulR, keepHiR;
  logic [DW-1:0] prodS;
  logic [W-1:0]  mulHi, mulLo;
  logic          mulSig;
  logic [W-1:0]  quotMag, remMag, quotOut, remOut;
  logic          rangeFault, divFault;

  always_comb begin
    isDivR  = opR[2];
    sgnDivR = opR[2] & opR[0];
    sgnMulR = (opR != OP_MULU);
    keepHiR = !opR[2] && !opR[1];
    prodS   = negRes ? (~shreg + 1'b1) : shreg;
    mulHi   = prodS[DW-1:W];
    mulLo   = prodS[W-1:0];
    mulSig  = sgnMulR ? (mulHi != {W{mulLo[W-1]}}) : (mulHi != '0);
    quotMag = shreg[W-1:0];
    remMag  = shreg[DW-1:W];
    quotOut = negRes ? (~quotMag + 1'b1) : quotMag;
    remOut  = negRem ? (~remMag + 1'b1) : remMag;
    rangeFault = negRes ? (quotMag > HALF_MAG) : quotMag[W-1];
    divFault   = preFault | (sgnDivR & rangeFault);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resHi     <= '0;
      resLo     <= '0;
      carryFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
    end else if (ctrl.finish) begin
      done <= 1'b1;
      if (isDivR) begin
        fault <= divFault;
        if (!divFault) begin
          resLo <= quotOut;
          resHi <= remOut;
        end
      end else begin
        fault     <= 1'b0;
        carryFlag <= mulSig;
        ovfFlag   <= mulSig;
        resLo     <= mulLo;
        if (keepHiR) resHi <= mulHi;
      end
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
    end
  end

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] dataIn,
  input  logic [W-1:0] srcIn,
  input  logic [W-1:0] immIn,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] resHi,
  output logic [W-1:0] resLo,
  output logic         carryFlag,
  output logic         ovfFlag
);

  mduCtrlS ctrl;

  mdu_ctrl #(.W(W)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy)
  );

  mdu_datapath #(.W(W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .op        (op),
    .accIn     (accIn),
    .dataIn    (dataIn),
    .srcIn     (srcIn),
    .immIn     (immIn),
    .resHi     (resHi),
    .resLo     (resLo),
    .carryFlag (carryFlag),
    .ovfFlag   (ovfFlag),
    .done      (done),
    .fault     (fault)
  );

endmodule

// File: rtl/mdu_unit_chk.sv
module mdu_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] resHi,
  input logic [W-1:0] resLo,
  input logic         carryFlag,
  input logic         ovfFlag
);

  // R8: a fault is only reported alongside completion
  assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);

  // R8: a faulting divide writes nothing
  assert_fault_keeps_results_R8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> ($stable(resHi) && $stable(resLo)));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: busy drops in the cycle done appears
  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));

  // R9: an accepted start makes the unit busy
  assert_start_takes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R4: the two multiply flags always agree when results are presented
  assert_flags_agree_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (carryFlag == ovfFlag));

endmodule

bind mdu_unit mdu_unit_chk #(.W(W)) i_mdu_unit_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .resHi     (resHi),
  .resLo     (resLo),
  .carryFlag (carryFlag),
  .ovfFlag   (ovfFlag)
);

// File: tb/test_mdu_unit.sv
module test_mdu_unit;

  localparam int W        = 8;
  localparam int CLK_PER  = 10;
  localparam int LATENCY  = W + 1;
  localparam int MAX_CYC  = 200000;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] acc;
    logic [W-1:0] dat;
    logic [W-1:0] src;
    logic [W-1:0] imm;
  } vecS;

  localparam int NV = 17;
  localparam vecS VECS [NV] = '{
    '{3'd0, 8'h12, 8'h00, 8'h34, 8'h00},  // R2 carry set
    '{3'd0, 8'h0F, 8'h00, 8'h0F, 8'h00},  // R2 carry clear
    '{3'd0, 8'hFF, 8'h00, 8'hFF, 8'h00},  // R2 max
    '{3'd1, 8'hFF, 8'h00, 8'h02, 8'h00},  // R3 -1*2
    '{3'd1, 8'h80, 8'h00, 8'h80, 8'h00},  // R3 min*min
    '{3'd2, 8'h10, 8'h00, 8'h10, 8'h00},  // R5 two-operand, overflow
    '{3'd3, 8'h55, 8'h00, 8'h07, 8'hFD},  // R5 three-operand -3*7
    '{3'd4, 8'h00, 8'h01, 8'h10, 8'h00},  // R6 256/16
    '{3'd4, 8'hFF, 8'h00, 8'h07, 8'h00},  // R6 255/7
    '{3'd4, 8'h00, 8'h05, 8'h05, 8'h00},  // R8 unsigned quotient too big
    '{3'd5, 8'hF9, 8'hFF, 8'h02, 8'h00},  // R7 -7/2
    '{3'd5, 8'h07, 8'h00, 8'hFE, 8'h00},  // R7 7/-2
    '{3'd5, 8'h80, 8'hFF, 8'hFF, 8'h00},  // R8 -128/-1
    '{3'd5, 8'h80, 8'hFF, 8'h01, 8'h00},  // R7 -128/1 fits
    '{3'd4, 8'h34, 8'h00, 8'h00, 8'h00},  // R8 divide by zero
    '{3'd5, 8'h80, 8'h3F, 8'h7F, 8'h00},  // R8 16256/127 = +128
    '{3'd6, 8'h81, 8'hC0, 8'h7F, 8'h00}   // R6 alternate code, unsigned
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] accIn = '0, dataIn = '0, srcIn = '0, immIn = '0;
  logic         busy, done, fault, carryFlag, ovfFlag;
  logic [W-1:0] resHi, resLo;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  mdu_unit #(.W(W)) i_mdu_unit (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .accIn(accIn), .dataIn(dataIn), .srcIn(srcIn), .immIn(immIn),
    .busy(busy), .done(done), .fault(fault),
    .resHi(resHi), .resLo(resLo), .carryFlag(carryFlag), .ovfFlag(ovfFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent reference from the requirements.
  task automatic model(input vecS v, inout logic [W-1:0] eHi, inout logic [W-1:0] eLo,
                       output bit eFault, output bit eCf, output bit isMul);
    longint p, dvd, dvs, q, r, fa;
    eFault = 1'b0; eCf = 1'b0;
    isMul = !v.op[2];
    if (isMul) begin
      if (v.op == 3'd0) begin
        p   = longint'(v.acc) * longint'(v.src);
        eCf = (p >= (longint'(1) << W));
      end else begin
        fa  = (v.op == 3'd3) ? longint'($signed(v.imm)) : longint'($signed(v.acc));
        p   = fa * longint'($signed(v.src));
        eCf = (p < -(longint'(1) << (W-1))) || (p > (longint'(1) << (W-1)) - 1);
      end
      eLo = p[W-1:0];
      if (v.op[1] == 1'b0) eHi = p[2*W-1:W];
    end else begin
      if (v.op[0]) begin
        dvd = longint'($signed({v.dat, v.acc}));
        dvs = longint'($signed(v.src));
      end else begin
        dvd = longint'({v.dat, v.acc});
        dvs = longint'(v.src);
      end
      if (dvs == 0) eFault = 1'b1;
      else begin
        q = dvd / dvs;
        r = dvd % dvs;
        if (v.op[0]) eFault = (q < -(longint'(1) << (W-1))) || (q > (longint'(1) << (W-1)) - 1);
        else         eFault = (q >= (longint'(1) << W));
        if (!eFault) begin
          eLo = q[W-1:0];
          eHi = r[W-1:0];
        end
      end
    end
  endtask

  task automatic runOp(input vecS v, input bit poke, output int cyc, output bit extraDone);
    @(negedge clk);
    op = v.op; accIn = v.acc; dataIn = v.dat; srcIn = v.src; immIn = v.imm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    extraDone = 1'b0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; op = 3'd0; accIn = '1; srcIn = '1; dataIn = '1; immIn = '1;
      end else begin
        start = 1'b0;
      end
    end
    if (poke) begin
      for (int k = 0; k < 2 * LATENCY; k++) begin
        @(negedge clk);
        if (done) extraDone = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", MAX_CYC, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] eHi, eLo;
    bit eFault, eCf, isMul, extra;
    int cyc;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(resHi == '0 && resLo == '0, "R1", "results after reset", {resHi, resLo}, 0);
    check(!carryFlag && !ovfFlag, "R1", "flags after reset", {carryFlag, ovfFlag}, 0);
    check(!busy && !done && !fault, "R1", "status after reset", {busy, done, fault}, 0);

    eHi = '0; eLo = '0;
    for (int i = 0; i < NV; i++) begin
      model(VECS[i], eHi, eLo, eFault, eCf, isMul);
      runOp(VECS[i], 1'b0, cyc, extra);
      // R9: latency of the completion pulse
      check(cyc == LATENCY && done, "R9", $sformatf("latency vec %0d", i), cyc, LATENCY);
      // R8: fault only for unrepresentable or zero-divisor divides
      check(fault == eFault, "R8", $sformatf("fault vec %0d", i), fault, eFault);
      // R2 R3 R5 R6 R7: result halves
      check(resHi == eHi, "R2/R3/R5/R6/R7", $sformatf("resHi vec %0d", i), resHi, eHi);
      check(resLo == eLo, "R2/R3/R5/R6/R7", $sformatf("resLo vec %0d", i), resLo, eLo);
      if (isMul) begin
        // R4: carry and overflow from significance of the high half
        check(carryFlag == eCf && ovfFlag == eCf, "R4",
              $sformatf("flags vec %0d", i), {carryFlag, ovfFlag}, {eCf, eCf});
      end
      @(negedge clk);
      check(!done && !busy, "R9", $sformatf("pulse ends vec %0d", i), {done, busy}, 0);
    end

    // R10: start during a run is ignored
    begin
      vecS pv;
      pv = '{3'd5, 8'hF9, 8'hFF, 8'h02, 8'h00};
      model(pv, eHi, eLo, eFault, eCf, isMul);
      runOp(pv, 1'b1, cyc, extra);
      check(cyc == LATENCY, "R10", "latency with mid-run start", cyc, LATENCY);
      check(resHi == eHi && resLo == eLo, "R10", "results with mid-run start",
            {resHi, resLo}, {eHi, eLo});
      check(!extra, "R10", "no second completion", extra, 0);
    end

    // R1: reset mid-operation returns to the reset state
    begin
      vecS rv;
      rv = '{3'd0, 8'hFF, 8'h00, 8'hFF, 8'h00};
      @(negedge clk);
      op = rv.op; accIn = rv.acc; srcIn = rv.src; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rstN = 1'b0;
      @(negedge clk);
      rstN = 1'b1;
      check(resHi == '0 && resLo == '0 && !busy && !done, "R1", "reset during run",
            {resHi, resLo, busy, done}, 0);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule